// File: doc/BRIEF.md
# Control Role Election and Deposition Flags

This block decides which one of a set of processors holds the control role. Each processor owns two visible flags. The first says that it is the controller. The second says that it believes the present controller is faulty. Every processor can read both flag vectors at all times.

A processor asks for the role by asserting its claim line. The hardware grants the role only while nobody holds it, so two controllers can never exist. A processor can raise or lower only its own fault flag. When enough processors other than the controller accuse it (two, by default), the hardware withdraws the role on its own. At that same edge it wipes every accusation, so a fresh election can start with the next claim.

A separate error output reports the case where more than one control flag is set. A correct design never reaches that case.

Top module: `ctrl_elect`

## Requirements
- R1: While `rst_n` is low, and on the first cycle after it, `ctrl_flags`, `sick_flags` and `conflict_err` are all zero.
- R2: If no control flag is set and at least one `claim_req` bit is high, exactly one claimant's control bit is set after the next rising clock edge. Processor i is bit i.
- R3: If several processors claim in the same cycle while the role is vacant, the claimant with the lowest index wins.
- R4: While a controller exists and it is not being deposed, `claim_req` is ignored and `ctrl_flags` stays unchanged.
- R5: `sick_set[i]` sets `sick_flags[i]` at the next edge. `sick_clr[i]` clears it. If both are high in the same cycle, set wins. No input of processor i changes any other processor's flag.
- R6: A `sick_set` from the processor that currently holds control is ignored, and its flag keeps its value.
- R7: An accusation is a set sick flag of a processor that is not the controller. When a controller exists and the accusations number at least ACCUSE_LIMIT (2 by default), `ctrl_flags` becomes zero at the next edge. A single accusation leaves the controller in place. A sick flag kept by the controller itself never counts.
- R8: At the edge where the role is withdrawn, all `sick_flags` are cleared and claims made in that cycle grant nothing. Claims made in the following cycle elect normally.
- R9: At most one bit of `ctrl_flags` is ever set. `conflict_err` is high exactly when more than one bit is set, so on a correct design it stays low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| claim_req | input | NPROC | Per-processor request for the control role |
| sick_set | input | NPROC | Per-processor request to raise its own fault flag |
| sick_clr | input | NPROC | Per-processor request to lower its own fault flag |
| ctrl_flags | output | NPROC | Bit i set: processor i holds the control role |
| sick_flags | output | NPROC | Bit i set: processor i believes the controller is faulty |
| conflict_err | output | 1 | More than one control flag is set |

## Verification
The assertions assume that only the bench drives the claim and fault lines, that the lines change only between clock edges, and that reset is held for at least one edge before it is released. The bench drives every input on the falling edge. It mixes directed sequences with random claim patterns and sparse random set and clear patterns. The sparse patterns let accusations build up over several cycles and reach the deposition threshold, which sends the flags through vacancy, election, accusation and withdrawal many times.

// File: rtl/ctrl_elect_pkg.sv
package ctrl_elect_pkg;
  localparam int unsigned MAX_PROC = 32;
  typedef logic [MAX_PROC-1:0] proc_vec_t;

  // Isolate the lowest set bit of a processor vector.
  function automatic proc_vec_t lowest_one(input proc_vec_t v);
    proc_vec_t r;
    r = '0;
    for (int i = MAX_PROC - 1; i >= 0; i--) begin
      if (v[i]) r = proc_vec_t'(1) << i;
    end
    return r;
  endfunction

  // Population count of a processor vector.
  function automatic int unsigned count_ones(input proc_vec_t v);
    int unsigned n;
    n = 0;
    for (int i = 0; i < MAX_PROC; i++) n += int'(v[i]);
    return n;
  endfunction
endpackage

// File: rtl/ctrl_elect_sick_bank.sv
module ctrl_elect_sick_bank #(
  parameter int unsigned NPROC = 5
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [NPROC-1:0] set_req,
  input  logic [NPROC-1:0] clr_req,
  input  logic [NPROC-1:0] holder,
  input  logic             wipe,
  output logic [NPROC-1:0] sick_q
);
  for (genvar i = 0; i < NPROC; i++) begin : g_flag
    logic take;
    // A controller's accusation against itself is dropped.
    assign take = set_req[i] & ~holder[i];

    always_ff @(posedge clk) begin
      if (!rst_n)         sick_q[i] <= 1'b0;
      else if (wipe)      sick_q[i] <= 1'b0;
      else if (take)      sick_q[i] <= 1'b1;
      else if (clr_req[i]) sick_q[i] <= 1'b0;
    end

    AST_SELF_ACCUSE_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
      holder[i] && set_req[i] && !clr_req[i] && !wipe |=> sick_q[i] == $past(sick_q[i])); // R6
    AST_OWN_WRITE_ONLY: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(sick_q[i]) |-> $past(set_req[i])); // R5
  end

  AST_WIPE_ALL: assert property (@(posedge clk) disable iff (!rst_n)
    wipe |=> sick_q == '0); // R8
endmodule

// File: rtl/ctrl_elect_arbiter.sv
module ctrl_elect_arbiter
  import ctrl_elect_pkg::*;
#(
  parameter int unsigned NPROC        = 5,
  parameter int unsigned ACCUSE_LIMIT = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [NPROC-1:0] claim_req,
  input  logic [NPROC-1:0] sick_flags,
  output logic [NPROC-1:0] ctrl_q,
  output logic             vacant,
  output logic             depose
);
  proc_vec_t       claim_wide;
  proc_vec_t       winner_wide;
  proc_vec_t       accuse_wide;
  int unsigned     accuse_cnt;
  logic [NPROC-1:0] grant_vec;

  assign claim_wide  = proc_vec_t'(claim_req);
  assign winner_wide = lowest_one(claim_wide);
  assign accuse_wide = proc_vec_t'(sick_flags & ~ctrl_q);
  assign accuse_cnt  = count_ones(accuse_wide);

  assign vacant    = (ctrl_q == '0);
  assign depose    = !vacant && (accuse_cnt >= ACCUSE_LIMIT);
  assign grant_vec = vacant ? winner_wide[NPROC-1:0] : '0;

  always_ff @(posedge clk) begin
    if (!rst_n)      ctrl_q <= '0;
    else if (depose) ctrl_q <= '0;
    else if (vacant) ctrl_q <= grant_vec;
  end

  AST_SINGLE_HOLDER: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(ctrl_q)); // R9
  AST_HOLDER_KEPT: assert property (@(posedge clk) disable iff (!rst_n)
    !vacant && !depose |=> ctrl_q == $past(ctrl_q)); // R4
  AST_DEPOSE_DROPS: assert property (@(posedge clk) disable iff (!rst_n)
    depose |=> ctrl_q == '0); // R7
  AST_GRANT_TO_CLAIMANT: assert property (@(posedge clk) disable iff (!rst_n)
    vacant |=> (ctrl_q & ~$past(claim_req)) == '0); // R2
  AST_VACANCY_FILLED: assert property (@(posedge clk) disable iff (!rst_n)
    vacant && claim_req != '0 |=> $countones(ctrl_q) == 1); // R2
endmodule

// File: rtl/ctrl_elect.sv
module ctrl_elect
  import ctrl_elect_pkg::*;
#(
  parameter int unsigned NPROC        = 5,
  parameter int unsigned ACCUSE_LIMIT = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [NPROC-1:0] claim_req,
  input  logic [NPROC-1:0] sick_set,
  input  logic [NPROC-1:0] sick_clr,
  output logic [NPROC-1:0] ctrl_flags,
  output logic [NPROC-1:0] sick_flags,
  output logic             conflict_err
);
  logic vacant;
  logic depose;

  ctrl_elect_arbiter #(.NPROC(NPROC), .ACCUSE_LIMIT(ACCUSE_LIMIT)) u_arb (
    .clk        (clk),
    .rst_n      (rst_n),
    .claim_req  (claim_req),
    .sick_flags (sick_flags),
    .ctrl_q     (ctrl_flags),
    .vacant     (vacant),
    .depose     (depose)
  );

  ctrl_elect_sick_bank #(.NPROC(NPROC)) u_sick (
    .clk     (clk),
    .rst_n   (rst_n),
    .set_req (sick_set),
    .clr_req (sick_clr),
    .holder  (ctrl_flags),
    .wipe    (depose),
    .sick_q  (sick_flags)
  );

  assign conflict_err = count_ones(proc_vec_t'(ctrl_flags)) > 1;

  AST_NO_CONFLICT: assert property (@(posedge clk) disable iff (!rst_n)
    !conflict_err); // R9
  AST_DEPOSE_NO_GRANT: assert property (@(posedge clk) disable iff (!rst_n)
    depose |=> ctrl_flags == '0 && sick_flags == '0); // R8
endmodule

// File: tb/ctrl_elect_test.sv
`timescale 1ns/1ps
module ctrl_elect_test;
  localparam int N = 5;
  localparam int LIMIT = 2;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [N-1:0] claim_req = '0, sick_set = '0, sick_clr = '0;
  logic [N-1:0] ctrl_flags, sick_flags;
  logic conflict_err;

  int checks = 0;
  int errors = 0;
  bit finished = 0;

  // Reference model state
  bit m_ctrl [N];
  bit m_sick [N];

  always #10 clk = ~clk;

  ctrl_elect #(.NPROC(N), .ACCUSE_LIMIT(LIMIT)) uut (
    .clk(clk), .rst_n(rst_n), .claim_req(claim_req), .sick_set(sick_set),
    .sick_clr(sick_clr), .ctrl_flags(ctrl_flags), .sick_flags(sick_flags),
    .conflict_err(conflict_err)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  function automatic logic [N-1:0] pack(input bit v [N]);
    logic [N-1:0] r;
    for (int i = 0; i < N; i++) r[i] = v[i];
    return r;
  endfunction

  task automatic compare_model();
    chk("model ctrl R2", 32'(ctrl_flags), 32'(pack(m_ctrl)));
    chk("model sick R5", 32'(sick_flags), 32'(pack(m_sick)));
    chk("conflict R9", 32'(conflict_err), 32'd0);
  endtask

  // Drive inputs at the falling edge, advance one rising edge, compare at the next falling edge.
  task automatic step(input logic [N-1:0] cl, input logic [N-1:0] st, input logic [N-1:0] cr);
    bit n_ctrl [N];
    bit n_sick [N];
    int accusers;
    bit held;
    bit found;
    claim_req = cl; sick_set = st; sick_clr = cr;
    accusers = 0; held = 0;
    for (int i = 0; i < N; i++) begin
      if (m_ctrl[i]) held = 1;
      if (m_sick[i] && !m_ctrl[i]) accusers++;
    end
    if (held && accusers >= LIMIT) begin
      for (int i = 0; i < N; i++) begin n_ctrl[i] = 0; n_sick[i] = 0; end
    end else begin
      found = 0;
      for (int i = 0; i < N; i++) begin
        n_ctrl[i] = m_ctrl[i];
        if (!held && !found && cl[i]) begin n_ctrl[i] = 1; found = 1; end
        if (st[i] && !m_ctrl[i]) n_sick[i] = 1;
        else if (cr[i])          n_sick[i] = 0;
        else                     n_sick[i] = m_sick[i];
      end
    end
    @(posedge clk);
    @(negedge clk);
    for (int i = 0; i < N; i++) begin m_ctrl[i] = n_ctrl[i]; m_sick[i] = n_sick[i]; end
    compare_model();
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      errors++;
      checks++;
      $display("FAIL watchdog expired");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    for (int i = 0; i < N; i++) begin m_ctrl[i] = 0; m_sick[i] = 0; end
    repeat (3) @(posedge clk);
    @(negedge clk);
    chk("R1 reset ctrl", 32'(ctrl_flags), 32'd0);
    chk("R1 reset sick", 32'(sick_flags), 32'd0);
    chk("R1 reset err", 32'(conflict_err), 32'd0);
    rst_n = 1'b1;
    step('0, '0, '0);
    chk("R1 after release", 32'(ctrl_flags), 32'd0);

    step(5'b01000, '0, '0);
    chk("R2 single claimant wins", 32'(ctrl_flags), 32'b01000);
    step(5'b00001, '0, '0);
    chk("R4 claim ignored while held", 32'(ctrl_flags), 32'b01000);
    step('0, 5'b00010, '0);
    chk("R5 own flag set", 32'(sick_flags), 32'b00010);
    chk("R7 one accusation keeps controller", 32'(ctrl_flags), 32'b01000);
    step('0, 5'b01000, '0);
    chk("R6 self accusation ignored", 32'(sick_flags), 32'b00010);
    step('0, 5'b10000, 5'b10010);
    chk("R5 clear own and set wins over clear", 32'(sick_flags), 32'b10000);
    step('0, 5'b00001, '0);
    chk("R7 two flags raised, not yet deposed", 32'(ctrl_flags), 32'b01000);
    step(5'b00110, '0, '0);
    chk("R7 controller withdrawn", 32'(ctrl_flags), 32'd0);
    chk("R8 accusations wiped", 32'(sick_flags), 32'd0);
    step(5'b10110, '0, '0);
    chk("R3 lowest claimant wins", 32'(ctrl_flags), 32'b00010);

    // The flag a controller raised before its election does not count.
    step('0, '0, '0);
    // Depose the controller at bit 1 first: processors 0 and 3 accuse it.
    step('0, 5'b01001, '0);
    step('0, '0, '0);
    chk("R8 vacancy after second deposition", 32'(ctrl_flags), 32'd0);
    step('0, 5'b00100, '0);
    step(5'b00100, '0, '0);
    chk("R2 accuser elected", 32'(ctrl_flags), 32'b00100);
    step('0, 5'b00001, '0);
    step('0, '0, '0);
    chk("R7 controller own flag excluded", 32'(ctrl_flags), 32'b00100);
    step('0, 5'b01000, '0);
    step('0, '0, '0);
    chk("R7 second outside accuser deposes", 32'(ctrl_flags), 32'd0);

    for (int k = 0; k < 600; k++) begin
      logic [N-1:0] cl, st, cr;
      cl = N'($urandom);
      st = N'($urandom & $urandom & $urandom);
      cr = N'($urandom & $urandom & $urandom);
      step(cl, st, cr);
    end

    finished = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule